// File: doc/BRIEF.md
# Byte/Word Arithmetic and Flag Unit

This block is the combinational arithmetic and data-move stage of a 16-bit microcontroller datapath. It takes an operation code, a size select, a destination operand, a source operand (which may already carry an immediate), and the current condition flags. From these it produces a result value, a writeback enable and the next N, Z, V, C flags. Operand fetch, addressing, the register file and instruction decode sit outside it.

Each operation class follows its own flag policy. Binary arithmetic recomputes all four flags. Address-style arithmetic writes a result and leaves the flags untouched. Packed-BCD arithmetic touches only Z and C. Moves and the byte swap set N and Z, clear V and keep C. Compare only sets flags and never writes back. A quick-add form accepts a small set of immediates and reports anything else as illegal.

A byte-size operation works on the low byte of each operand. The upper byte of the destination passes through to the result unchanged, so the caller can always write the full word back.

Top module: `byteWordAlu`

## Requirements
- R1: With `wordSize`=0, results and flags come from bits 7:0 only, and `result[15:8]` equals `dstVal[15:8]`. With `wordSize`=1, all 16 bits are used. The flag vector is N=bit 3, Z=bit 2, V=bit 1, C=bit 0.
- R2: ADD (opcode 2), SUB (3) and the carry forms update all four flags. N is the top bit of the active width. Z is set when the active-width result is zero. V is two's-complement overflow. C is the carry out for addition and the borrow for subtraction.
- R3: ADDC (4) computes dst+src+C. SUBC (5) computes dst−src−C, with C taken from `flagsIn`.
- R4: ADDNF (6) and SUBNF (7) write dst+src and dst−src respectively, and `flagsOut` equals `flagsIn`.
- R5: DADD (8) and DSUB (9) treat the low bytes as two packed BCD digits and include C as the carry or borrow in. The result is a byte regardless of `wordSize`. Only Z and C change, with C being the decimal carry or borrow out. N and V are kept.
- R6: MOVE (0) passes the source at the active width. It sets N and Z from the moved value, clears V and keeps C.
- R7: SWAP (1) returns `{dstVal[7:0], dstVal[15:8]}` regardless of `wordSize`. N and Z come from the low byte of that result. V is cleared and C is kept.
- R8: CMP (10) sets all four flags exactly as SUB would and keeps `writeEn` low.
- R9: QADD (11) adds the source at the active width when `srcVal` is 16'h0001, 16'h0002, 16'hFFFF or 16'hFFFE, updating all flags. Any other source raises `illegal`, lowers `writeEn` and keeps the flags.
- R10: Opcodes 12 to 15 raise `illegal`, lower `writeEn` and keep the flags. Every legal opcode other than CMP asserts `writeEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code |
| wordSize | input | 1 | 1 = word, 0 = byte |
| dstVal | input | 16 | Destination operand |
| srcVal | input | 16 | Source operand or immediate |
| flagsIn | input | 4 | Current flags {N,Z,V,C} |
| result | output | 16 | Value to write back |
| writeEn | output | 1 | Writeback enable |
| flagsOut | output | 4 | Next flags {N,Z,V,C} |
| illegal | output | 1 | Unsupported opcode or quick immediate |

## Verification
The unit holds no registers, so every output is due in the same cycle as the inputs that produce it, with no latency to count. The bench changes all inputs together on the falling clock edge. It samples `result`, `writeEn`, `flagsOut` and `illegal` one nanosecond later, well before the next rising edge, so each vector is judged against only its own stimulus. Expected values come from integer and decimal reference functions in the bench. Seeded random vectors are mixed with directed carry, overflow, BCD wrap and illegal-immediate cases.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;

  typedef enum logic [3:0] {
    OP_MOVE  = 4'd0,
    OP_SWAP  = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_ADDC  = 4'd4,
    OP_SUBC  = 4'd5,
    OP_ADDNF = 4'd6,
    OP_SUBNF = 4'd7,
    OP_DADD  = 4'd8,
    OP_DSUB  = 4'd9,
    OP_CMP   = 4'd10,
    OP_QADD  = 4'd11
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selMove;
    logic selSwap;
    logic selBcd;
    logic selSub;
    logic useCarry;
    logic updNZ;
    logic updZ;
    logic updV;
    logic clrV;
    logic updC;
  } aluCtrl_t;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [3:0] opSel,
  output aluCtrl_t   ctrl,
  output logic       wrReq,
  output logic       chkQuick,
  output logic       badOp
);
  always_comb begin
    ctrl     = '0;
    wrReq    = 1'b0;
    chkQuick = 1'b0;
    badOp    = 1'b0;
    case (opSel)
      OP_MOVE: begin
        ctrl.selMove = 1'b1; ctrl.updNZ = 1'b1; ctrl.clrV = 1'b1; wrReq = 1'b1;
      end
      OP_SWAP: begin
        ctrl.selSwap = 1'b1; ctrl.updNZ = 1'b1; ctrl.clrV = 1'b1; wrReq = 1'b1;
      end
      OP_ADD, OP_QADD: begin
        ctrl.updNZ = 1'b1; ctrl.updV = 1'b1; ctrl.updC = 1'b1; wrReq = 1'b1;
        chkQuick = (opSel == OP_QADD);
      end
      OP_SUB, OP_CMP: begin
        ctrl.selSub = 1'b1;
        ctrl.updNZ = 1'b1; ctrl.updV = 1'b1; ctrl.updC = 1'b1;
        wrReq = (opSel == OP_SUB);
      end
      OP_ADDC, OP_SUBC: begin
        ctrl.selSub = (opSel == OP_SUBC); ctrl.useCarry = 1'b1;
        ctrl.updNZ = 1'b1; ctrl.updV = 1'b1; ctrl.updC = 1'b1; wrReq = 1'b1;
      end
      OP_ADDNF, OP_SUBNF: begin
        ctrl.selSub = (opSel == OP_SUBNF); wrReq = 1'b1;
      end
      OP_DADD, OP_DSUB: begin
        ctrl.selBcd = 1'b1; ctrl.selSub = (opSel == OP_DSUB);
        ctrl.useCarry = 1'b1; ctrl.updZ = 1'b1; ctrl.updC = 1'b1; wrReq = 1'b1;
      end
      default: badOp = 1'b1;
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  aluCtrl_t          ctrl,
  input  logic              wordSize,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] resVal,
  output logic [3:0]        flagsNext,
  output logic              quickOk
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int LANES  = 2;

  logic carryIn;
  assign carryIn = ctrl.useCarry & flagsIn[FLAG_C];

  logic [DATA_W-1:0] laneRes [LANES];
  logic              laneC   [LANES];
  logic              laneV   [LANES];

  // lane 0 is byte width, lane 1 is word width
  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int LW = BYTE_W * (g + 1);
    logic [LW-1:0] opA, opB, sum;
    logic [LW:0]   sumX, diffX;
    assign opA   = dstVal[LW-1:0];
    assign opB   = srcVal[LW-1:0];
    assign sumX  = {1'b0, opA} + {1'b0, opB} + {{LW{1'b0}}, carryIn};
    assign diffX = {1'b0, opA} - {1'b0, opB} - {{LW{1'b0}}, carryIn};
    assign sum   = ctrl.selSub ? diffX[LW-1:0] : sumX[LW-1:0];
    always_comb begin
      laneRes[g] = '0;
      laneRes[g][LW-1:0] = sum;
      laneC[g] = ctrl.selSub ? diffX[LW] : sumX[LW];
      if (ctrl.selSub)
        laneV[g] = (opA[LW-1] ^ opB[LW-1]) & (sum[LW-1] ^ opA[LW-1]);
      else
        laneV[g] = ~(opA[LW-1] ^ opB[LW-1]) & (sum[LW-1] ^ opA[LW-1]);
    end
  end

  // packed BCD on the low byte, two digits
  logic [4:0] loDig, hiDig;
  logic [3:0] loFix, hiFix;
  logic       digCarry, bcdCarry;
  always_comb begin
    if (ctrl.selSub) begin
      loDig    = {1'b0, dstVal[3:0]} - {1'b0, srcVal[3:0]} - {4'd0, carryIn};
      digCarry = loDig[4];
      loFix    = digCarry ? loDig[3:0] - 4'd6 : loDig[3:0];
      hiDig    = {1'b0, dstVal[7:4]} - {1'b0, srcVal[7:4]} - {4'd0, digCarry};
      bcdCarry = hiDig[4];
      hiFix    = bcdCarry ? hiDig[3:0] - 4'd6 : hiDig[3:0];
    end else begin
      loDig    = {1'b0, dstVal[3:0]} + {1'b0, srcVal[3:0]} + {4'd0, carryIn};
      digCarry = (loDig > 5'd9);
      loFix    = digCarry ? loDig[3:0] + 4'd6 : loDig[3:0];
      hiDig    = {1'b0, dstVal[7:4]} + {1'b0, srcVal[7:4]} + {4'd0, digCarry};
      bcdCarry = (hiDig > 5'd9);
      hiFix    = bcdCarry ? hiDig[3:0] + 4'd6 : hiDig[3:0];
    end
  end

  logic [DATA_W-1:0] upperKeep;
  logic              effWord;
  logic              nRaw, zRaw, vRaw, cRaw;
  always_comb begin
    upperKeep = dstVal;
    upperKeep[BYTE_W-1:0] = '0;
    effWord = wordSize & ~ctrl.selSwap & ~ctrl.selBcd;
    if (ctrl.selMove)
      resVal = wordSize ? srcVal : (upperKeep | {{BYTE_W{1'b0}}, srcVal[BYTE_W-1:0]});
    else if (ctrl.selSwap)
      resVal = {dstVal[BYTE_W-1:0], dstVal[DATA_W-1:BYTE_W]};
    else if (ctrl.selBcd)
      resVal = upperKeep | {{(DATA_W-8){1'b0}}, hiFix, loFix};
    else if (wordSize)
      resVal = laneRes[1];
    else
      resVal = upperKeep | laneRes[0];
    nRaw = effWord ? resVal[DATA_W-1] : resVal[BYTE_W-1];
    zRaw = effWord ? (resVal == '0) : (resVal[BYTE_W-1:0] == '0);
    vRaw = wordSize ? laneV[1] : laneV[0];
    cRaw = ctrl.selBcd ? bcdCarry : (wordSize ? laneC[1] : laneC[0]);
  end

  always_comb begin
    flagsNext[FLAG_N] = ctrl.updNZ ? nRaw : flagsIn[FLAG_N];
    flagsNext[FLAG_Z] = (ctrl.updNZ | ctrl.updZ) ? zRaw : flagsIn[FLAG_Z];
    flagsNext[FLAG_V] = ctrl.updV ? vRaw : (ctrl.clrV ? 1'b0 : flagsIn[FLAG_V]);
    flagsNext[FLAG_C] = ctrl.updC ? cRaw : flagsIn[FLAG_C];
  end

  localparam logic [DATA_W-1:0] IMM_P1 = DATA_W'(1);
  localparam logic [DATA_W-1:0] IMM_P2 = DATA_W'(2);
  localparam logic [DATA_W-1:0] IMM_M1 = '1;
  localparam logic [DATA_W-1:0] IMM_M2 = IMM_M1 - IMM_P1;
  assign quickOk = (srcVal == IMM_P1) | (srcVal == IMM_P2) |
                   (srcVal == IMM_M1) | (srcVal == IMM_M2);
endmodule

// File: rtl/byteWordAlu.sv
module byteWordAlu
  import aluPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        opSel,
  input  logic              wordSize,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [3:0]        flagsOut,
  output logic              illegal
);
  aluCtrl_t   ctrl;
  logic       wrReq, chkQuick, badOp, quickOk;
  logic [3:0] dpFlags;

  aluControl uCtrl (
    .opSel(opSel), .ctrl(ctrl), .wrReq(wrReq),
    .chkQuick(chkQuick), .badOp(badOp)
  );

  aluDatapath #(.DATA_W(DATA_W)) uDp (
    .ctrl(ctrl), .wordSize(wordSize), .dstVal(dstVal), .srcVal(srcVal),
    .flagsIn(flagsIn), .resVal(result), .flagsNext(dpFlags), .quickOk(quickOk)
  );

  assign illegal  = badOp | (chkQuick & ~quickOk);
  assign writeEn  = wrReq & ~illegal;
  assign flagsOut = illegal ? flagsIn : dpFlags;
endmodule

// File: rtl/byteWordAluChecker.sv
module byteWordAluChecker #(
  parameter int DATA_W = 16
) (
  input logic [3:0]        opSel,
  input logic              wordSize,
  input logic [DATA_W-1:0] dstVal,
  input logic [DATA_W-1:0] srcVal,
  input logic [3:0]        flagsIn,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic [3:0]        flagsOut,
  input logic              illegal
);
  localparam int BYTE_W = DATA_W / 2;
  logic quickLegal;
  assign quickLegal = (srcVal == DATA_W'(1)) || (srcVal == DATA_W'(2)) ||
                      (srcVal == {DATA_W{1'b1}}) || (srcVal == ({DATA_W{1'b1}} - DATA_W'(1)));

  always_comb begin
    // R1: byte operations keep the destination upper byte
    a_r1_upper_kept: assert (!(writeEn && !wordSize && opSel != 4'd1) ||
                             result[DATA_W-1:BYTE_W] == dstVal[DATA_W-1:BYTE_W]);
    // R4: flag-free arithmetic keeps all flags
    a_r4_flags_held: assert (!(opSel == 4'd6 || opSel == 4'd7) ||
                             (flagsOut == flagsIn && writeEn));
    // R5: decimal ops keep N and V
    a_r5_nv_held: assert (!(opSel == 4'd8 || opSel == 4'd9) ||
                          (flagsOut[3] == flagsIn[3] && flagsOut[1] == flagsIn[1]));
    // R6: moves clear V and keep C
    a_r6_move_flags: assert (!(opSel == 4'd0) ||
                             (!flagsOut[1] && flagsOut[0] == flagsIn[0]));
    // R8: compare never writes back
    a_r8_no_write: assert (!(opSel == 4'd10) || !writeEn);
    // R9: quick add legality follows the immediate
    a_r9_quick_illegal: assert (!(opSel == 4'd11) || (illegal == !quickLegal));
    // R10: illegal means no write and unchanged flags
    a_r10_illegal_inert: assert (!illegal || (!writeEn && flagsOut == flagsIn));
  end
endmodule

bind byteWordAlu byteWordAluChecker #(.DATA_W(DATA_W)) uChk (
  .opSel(opSel), .wordSize(wordSize), .dstVal(dstVal), .srcVal(srcVal),
  .flagsIn(flagsIn), .result(result), .writeEn(writeEn),
  .flagsOut(flagsOut), .illegal(illegal)
);

// File: tb/byteWordAlu_test.sv
module byteWordAlu_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  opSel;
  logic        wordSize;
  logic [15:0] dstVal, srcVal;
  logic [3:0]  flagsIn;
  logic [15:0] result;
  logic        writeEn, illegal;
  logic [3:0]  flagsOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  byteWordAlu uut (
    .opSel(opSel), .wordSize(wordSize), .dstVal(dstVal), .srcVal(srcVal),
    .flagsIn(flagsIn), .result(result), .writeEn(writeEn),
    .flagsOut(flagsOut), .illegal(illegal)
  );

  typedef struct packed {
    logic [15:0] res;
    logic        we;
    logic [3:0]  fl;
    logic        ill;
  } expect_t;

  function automatic string tagOf(int op);
    case (op)
      0: return "R6";   1: return "R7";
      2, 3: return "R2"; 4, 5: return "R3";
      6, 7: return "R4"; 8, 9: return "R5";
      10: return "R8";  11: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic int bcdVal(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic expect_t model(int op, bit ws, logic [15:0] d, logic [15:0] s,
                                    logic [3:0] f);
    expect_t e;
    int w    = ws ? 16 : 8;
    int mask = ws ? 32'hFFFF : 32'hFF;
    int a    = int'(d) & mask;
    int b    = int'(s) & mask;
    int half = 1 << (w - 1);
    int sa   = (a >= half) ? a - (1 << w) : a;
    int sb   = (b >= half) ? b - (1 << w) : b;
    int cin  = 0;
    int r    = 0;
    int sv;
    int full;
    e.fl  = f;
    e.we  = 1'b1;
    e.ill = 1'b0;
    e.res = 16'h0;
    if (op == 4 || op == 5 || op == 8 || op == 9) cin = int'(f[0]);
    if (op == 11 && !(s == 16'h0001 || s == 16'h0002 || s == 16'hFFFF || s == 16'hFFFE))
      op = 99;
    case (op)
      0: begin
        r = b; e.fl[1] = 1'b0;
        e.fl[3] = (r >= half); e.fl[2] = (r == 0);
      end
      1: begin
        e.res = {d[7:0], d[15:8]};
        e.fl[3] = d[15]; e.fl[2] = (d[15:8] == 8'h00); e.fl[1] = 1'b0;
        return e;
      end
      2, 4, 6, 11: begin
        full = a + b + cin; sv = sa + sb + cin; r = full & mask;
        if (op != 6) begin
          e.fl[0] = (full > mask); e.fl[1] = (sv >= half) || (sv < -half);
          e.fl[3] = (r >= half);   e.fl[2] = (r == 0);
        end
      end
      3, 5, 7, 10: begin
        full = a - b - cin; sv = sa - sb - cin; r = full & mask;
        if (op != 7) begin
          e.fl[0] = (full < 0);    e.fl[1] = (sv >= half) || (sv < -half);
          e.fl[3] = (r >= half);   e.fl[2] = (r == 0);
        end
        if (op == 10) e.we = 1'b0;
      end
      8, 9: begin
        full = (op == 8) ? bcdVal(d[7:0]) + bcdVal(s[7:0]) + cin
                         : bcdVal(d[7:0]) - bcdVal(s[7:0]) - cin;
        e.fl[0] = (op == 8) ? (full > 99) : (full < 0);
        if (full < 0) full += 100;
        full = full % 100;
        e.res = {d[15:8], 4'(full / 10), 4'(full % 10)};
        e.fl[2] = (full == 0);
        return e;
      end
      default: begin
        e.we = 1'b0; e.ill = 1'b1; e.res = result; // result is don't-care here
        return e;
      end
    endcase
    e.res = ws ? 16'(r) : {d[15:8], 8'(r)};
    return e;
  endfunction

  task automatic runVec(int op, bit ws, logic [15:0] d, logic [15:0] s, logic [3:0] f,
                        string note);
    expect_t e;
    @(negedge clk);
    opSel = 4'(op); wordSize = ws; dstVal = d; srcVal = s; flagsIn = f;
    #1;
    e = model(op, ws, d, s, f);
    checks++;
    if (result !== e.res || writeEn !== e.we || flagsOut !== e.fl || illegal !== e.ill) begin
      fails++;
      $display("FAIL %s %s op=%0d ws=%0d d=%h s=%h f=%b: got res=%h we=%b fl=%b ill=%b, expected res=%h we=%b fl=%b ill=%b",
               tagOf(op), note, op, ws, d, s, f, result, writeEn, flagsOut, illegal,
               e.res, e.we, e.fl, e.ill);
    end
  endtask

  function automatic logic [7:0] randBcd();
    return {4'($urandom % 10), 4'($urandom % 10)};
  endfunction

  initial begin
    opSel = 4'd0; wordSize = 1'b0; dstVal = '0; srcVal = '0; flagsIn = '0;
    void'($urandom(32'd20240611));
    // idle state: byte move of zero sets Z only (R6, R1)
    runVec(0, 0, 16'h0000, 16'h0000, 4'b0000, "idle move of zero");
    // R2 byte overflow 7F+1 and word carry FFFF+1
    runVec(2, 0, 16'h127F, 16'h0001, 4'b0000, "R2 byte overflow");
    runVec(2, 1, 16'hFFFF, 16'h0001, 4'b0000, "R2 word carry to zero");
    runVec(3, 1, 16'h8000, 16'h0001, 4'b0000, "R2 word sub overflow");
    // R3 carry consumed
    runVec(5, 0, 16'h0000, 16'h0000, 4'b0001, "R3 subc borrow from C");
    runVec(4, 1, 16'h7FFF, 16'h0000, 4'b0001, "R3 addc overflow from C");
    // R4 flag-free keeps flags
    runVec(6, 1, 16'hFFFF, 16'h0001, 4'b1010, "R4 addnf keeps flags");
    // R5 BCD wraps
    runVec(8, 0, 16'hAB99, 16'h0001, 4'b1010, "R5 99+01 wraps");
    runVec(9, 1, 16'h0000, 16'h0001, 4'b0000, "R5 00-01 borrows");
    runVec(8, 0, 16'h0045, 16'h0054, 4'b0001, "R5 45+54+1");
    // R7 swap
    runVec(1, 1, 16'h00AB, 16'h1234, 4'b0011, "R7 swap zero low");
    runVec(1, 0, 16'h8001, 16'h0000, 4'b0100, "R7 swap negative");
    // R8 compare equal
    runVec(10, 1, 16'h1234, 16'h1234, 4'b0000, "R8 compare equal");
    // R9 quick immediates
    runVec(11, 0, 16'h5500, 16'hFFFF, 4'b0000, "R9 quick -1 byte");
    runVec(11, 1, 16'hFFFE, 16'h0002, 4'b0000, "R9 quick +2 word");
    runVec(11, 1, 16'h0010, 16'h0003, 4'b1111, "R9 quick +3 illegal");
    // R10 undefined opcodes
    for (int op = 12; op < 16; op++)
      runVec(op, 1, 16'h1111, 16'h2222, 4'b0101, "R10 undefined opcode");
    // seeded random mix
    for (int i = 0; i < 6000; i++) begin
      int op = int'($urandom % 16);
      bit ws = 1'($urandom);
      logic [15:0] d = 16'($urandom);
      logic [15:0] s = 16'($urandom);
      logic [3:0]  f = 4'($urandom);
      if (op == 8 || op == 9) begin
        d[7:0] = randBcd(); s[7:0] = randBcd();
      end
      if (op == 11 && ($urandom % 4) != 0) begin
        case ($urandom % 4)
          0: s = 16'h0001; 1: s = 16'h0002; 2: s = 16'hFFFF; default: s = 16'hFFFE;
        endcase
      end
      runVec(op, ws, d, s, f, "random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule